// File: doc/BRIEF.md
# Interprocessor Interrupt Target Resolver

This block lives inside a per-context local interrupt controller. Each time software writes the low word of the command register, the block turns the request into concrete targets. It reads the destination shorthand, the addressing mode, the 8-bit destination, the vector, the delivery mode and the trigger mode. It also reads the controller's own ID. From these it produces a per-context mask of remote targets and a strobe that raises the interrupt on the controller itself. Unsupported delivery modes set an error flag instead of producing targets.

The controller's own ID is always removed from the remote mask and delivered locally. This holds whether the ID was named directly, through a logical bit, through a broadcast or through a shorthand. A running counter of outstanding outgoing interrupts grows by the number of remote targets of each request. The context count `NCTX` (1 to 8) and the counter width `CNT_W` are parameters. All results are registered and qualified by a one-cycle valid pulse.

Top module: `ipi_target_resolver`

## Requirements
- R1: During and straight after reset, `out_valid`, `remote_mask`, `local_raise`, `req_err` and `pending_cnt` are all zero.
- R2: A write sampled at a rising edge makes `out_valid` high for exactly the following cycle, unless another write is sampled at the next edge. While `out_valid` is low, `remote_mask`, `local_raise` and `req_err` are zero.
- R3: With shorthand 2'd0 and `logical_mode`=1, bit i of `dest` (for i < NCTX) selects context i. A selected context equal to `self_id` is raised locally instead of being placed in the mask.
- R4: With shorthand 2'd0, `logical_mode`=0 and `dest`=8'hFF, every context below NCTX is targeted. If `self_id` is below NCTX, that context is raised locally and is left out of the mask.
- R5: With shorthand 2'd0, `logical_mode`=0 and any other `dest`: a `dest` equal to `self_id` raises locally with an empty mask; a `dest` below NCTX sets only that bit; a `dest` at or above NCTX gives an empty mask.
- R6: Shorthand 2'd1 raises locally only, with an empty mask.
- R7: Shorthand 2'd2 raises locally and sets every context other than `self_id` in the mask.
- R8: Shorthand 2'd3 sets every context other than `self_id` in the mask and does not raise locally.
- R9: Delivery mode 3'b001 (lowest priority) and the reserved codes 3'b011 and 3'b110 set `req_err`. They leave the mask empty and `local_raise` low, and the counter unchanged.
- R10: On every valid request, `pending_cnt` grows by the number of set bits in `remote_mask`, modulo 2^CNT_W. It never changes otherwise.
- R11: When `local_raise` is high, `local_vector`, `local_dmode` and `local_trig` equal the vector, delivery mode and trigger of the request that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the command word |
| shorthand | input | 2 | Destination shorthand: 0 field, 1 self, 2 all, 3 all but self |
| logical_mode | input | 1 | 1 selects logical (bit-per-context) addressing |
| dest | input | 8 | Destination field |
| vector | input | 8 | Interrupt vector |
| dmode | input | 3 | Delivery mode |
| trig_level | input | 1 | Trigger mode, 1 for level |
| self_id | input | 8 | This controller's ID |
| out_valid | output | 1 | Result qualifier, one cycle per write |
| remote_mask | output | NCTX | One bit per remote target context |
| local_raise | output | 1 | Raise the interrupt on this controller |
| local_vector | output | 8 | Vector for the local raise |
| local_dmode | output | 3 | Delivery mode for the local raise |
| local_trig | output | 1 | Trigger mode for the local raise |
| req_err | output | 1 | Request rejected for its delivery mode |
| pending_cnt | output | CNT_W | Running count of outstanding remote interrupts |

## Verification
The assertions relate each valid result to the request fields as sampled one edge earlier. They therefore assume that `self_id` and the command fields are steady only at the sampling edge, and need nothing after it. They also assume `self_id` is meaningful, possibly at or above NCTX. The bench changes every input only on falling edges and draws random values for all fields. It biases `dest` toward 8'hFF, toward `self_id` and toward IDs past the context count. Draws of `self_id` include values outside the context range, so the "no self" cases are reached.

// File: rtl/ipi_target_resolver.sv
module ipi_target_resolver #(
  parameter int NCTX  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       shorthand,
  input  logic             logical_mode,
  input  logic [7:0]       dest,
  input  logic [7:0]       vector,
  input  logic [2:0]       dmode,
  input  logic             trig_level,
  input  logic [7:0]       self_id,
  output logic             out_valid,
  output logic [NCTX-1:0]  remote_mask,
  output logic             local_raise,
  output logic [7:0]       local_vector,
  output logic [2:0]       local_dmode,
  output logic             local_trig,
  output logic             req_err,
  output logic [CNT_W-1:0] pending_cnt
);
  localparam int PC_W = $clog2(NCTX + 1);

  logic [NCTX-1:0] self_oh, dest_oh, all_ctx, tgt, rmask_n;
  logic            loc_n, bad_mode;
  logic [PC_W-1:0] pc_n;

  for (genvar i = 0; i < NCTX; i++) begin : g_oh
    assign self_oh[i] = (self_id == 8'(i));
    assign dest_oh[i] = (dest == 8'(i));
  end

  assign all_ctx  = '1;
  assign bad_mode = (dmode == 3'b001) || (dmode == 3'b011) || (dmode == 3'b110);

  always_comb begin
    tgt   = '0;
    loc_n = 1'b0;
    unique case (shorthand)
      2'd0: begin
        if (logical_mode) begin
          tgt   = dest[NCTX-1:0];
          loc_n = |(dest[NCTX-1:0] & self_oh);
        end else if (dest == 8'hFF) begin
          tgt   = all_ctx;
          loc_n = |self_oh;
        end else begin
          tgt   = dest_oh;
          loc_n = (dest == self_id);
        end
      end
      2'd1: loc_n = 1'b1;
      2'd2: begin
        tgt   = all_ctx;
        loc_n = 1'b1;
      end
      default: tgt = all_ctx;
    endcase
    if (bad_mode) begin
      tgt   = '0;
      loc_n = 1'b0;
    end
  end

  assign rmask_n = tgt & ~self_oh;

  always_comb begin
    pc_n = '0;
    for (int i = 0; i < NCTX; i++) pc_n = pc_n + PC_W'(rmask_n[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      remote_mask  <= '0;
      local_raise  <= 1'b0;
      local_vector <= '0;
      local_dmode  <= '0;
      local_trig   <= 1'b0;
      req_err      <= 1'b0;
      pending_cnt  <= '0;
    end else begin
      out_valid   <= wr_en;
      remote_mask <= wr_en ? rmask_n : '0;
      local_raise <= wr_en & loc_n;
      req_err     <= wr_en & bad_mode;
      if (wr_en) begin
        local_vector <= vector;
        local_dmode  <= dmode;
        local_trig   <= trig_level;
        pending_cnt  <= pending_cnt + CNT_W'(pc_n);
      end
    end
  end
endmodule

module ipi_resolver_chk #(
  parameter int NCTX  = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       shorthand,
  input logic             logical_mode,
  input logic [7:0]       dest,
  input logic [7:0]       vector,
  input logic [2:0]       dmode,
  input logic             trig_level,
  input logic [7:0]       self_id,
  input logic             out_valid,
  input logic [NCTX-1:0]  remote_mask,
  input logic             local_raise,
  input logic [7:0]       local_vector,
  input logic [2:0]       local_dmode,
  input logic             local_trig,
  input logic             req_err,
  input logic [CNT_W-1:0] pending_cnt
);
  function automatic logic [NCTX-1:0] oh_of(input logic [7:0] id);
    logic [NCTX-1:0] r;
    for (int i = 0; i < NCTX; i++) r[i] = (id == 8'(i));
    return r;
  endfunction

  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(wr_en));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (remote_mask == '0 && !local_raise && !req_err));

  p_self_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((remote_mask & oh_of($past(self_id))) == '0));

  p_self_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !req_err && $past(shorthand) == 2'd1) |-> (local_raise && remote_mask == '0));

  p_no_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(shorthand) == 2'd3) |-> !local_raise);

  p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (remote_mask == '0 && !local_raise && pending_cnt == $past(pending_cnt)));

  p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pending_cnt == CNT_W'($past(pending_cnt) + CNT_W'($countones(remote_mask))));

  p_payload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    local_raise |-> (local_vector == $past(vector) && local_dmode == $past(dmode)
                     && local_trig == $past(trig_level)));
endmodule

bind ipi_target_resolver ipi_resolver_chk #(.NCTX(NCTX), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_ipi_target_resolver.sv
`timescale 1ns/1ps
module tb_ipi_target_resolver;
  localparam int NCTX  = 8;
  localparam int CNT_W = 16;

  logic clk = 0, rst_n = 0, wr_en = 0, logical_mode = 0, trig_level = 0;
  logic [1:0] shorthand = 0;
  logic [7:0] dest = 0, vector = 0, self_id = 0;
  logic [2:0] dmode = 0;
  logic out_valid, local_raise, local_trig, req_err;
  logic [NCTX-1:0] remote_mask;
  logic [7:0] local_vector;
  logic [2:0] local_dmode;
  logic [CNT_W-1:0] pending_cnt;

  int n_chk = 0, n_fail = 0;
  logic [CNT_W-1:0] exp_cnt = 0;

  always #5 clk = ~clk;

  ipi_target_resolver #(.NCTX(NCTX), .CNT_W(CNT_W)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCTX-1:0] ref_mask(input logic [1:0] sh, input logic lg,
      input logic [7:0] d, input logic [2:0] dm, input logic [7:0] sid, output logic loc, output logic er);
    logic [NCTX-1:0] m = '0;
    er  = (dm == 3'b001 || dm == 3'b011 || dm == 3'b110);
    loc = 0;
    if (sh == 2'd0 && lg) begin
      for (int i = 0; i < NCTX; i++)
        if (d[i]) begin if (sid == i) loc = 1; else m[i] = 1; end
    end else if (sh == 2'd0 && d == 8'hFF) begin
      for (int i = 0; i < NCTX; i++) begin if (sid == i) loc = 1; else m[i] = 1; end
    end else if (sh == 2'd0) begin
      if (d == sid) loc = 1;
      else if (d < NCTX) m[d[2:0]] = 1;
    end else begin
      loc = (sh != 2'd3);
      if (sh != 2'd1)
        for (int i = 0; i < NCTX; i++) if (sid != i) m[i] = 1;
    end
    if (er) begin m = '0; loc = 0; end
    return m;
  endfunction

  function automatic int popc(input logic [NCTX-1:0] m);
    int c = 0;
    for (int i = 0; i < NCTX; i++) c += m[i];
    return c;
  endfunction

  task automatic req(input string tag, input logic [1:0] sh, input logic lg, input logic [7:0] d,
      input logic [2:0] dm, input logic [7:0] sid, input logic [7:0] vec, input logic tr);
    logic loc, er;
    logic [NCTX-1:0] m;
    m = ref_mask(sh, lg, d, dm, sid, loc, er);
    shorthand = sh; logical_mode = lg; dest = d; dmode = dm; self_id = sid;
    vector = vec; trig_level = tr; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    exp_cnt = exp_cnt + CNT_W'(popc(m));
    chk({tag, " R2 valid"}, 32'(out_valid), 1);
    chk({tag, " mask"}, 32'(remote_mask), 32'(m));
    chk({tag, " local"}, 32'(local_raise), 32'(loc));
    chk({tag, " R9 err"}, 32'(req_err), 32'(er));
    chk({tag, " R10 count"}, 32'(pending_cnt), 32'(exp_cnt));
    if (loc) chk({tag, " R11 payload"}, {20'd0, local_trig, local_dmode, local_vector},
                 {20'd0, tr, dm, vec});
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 valid", 32'(out_valid), 0);
    chk("R1 count", 32'(pending_cnt), 0);
    chk("R1 mask", 32'(remote_mask), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", {out_valid, local_raise, req_err, remote_mask}, 0);

    req("R3 logical", 2'd0, 1, 8'hA5, 3'd0, 8'd2, 8'h31, 0);
    req("R3 logical self", 2'd0, 1, 8'h0C, 3'd0, 8'd2, 8'h32, 1);
    req("R4 broadcast", 2'd0, 0, 8'hFF, 3'd0, 8'd5, 8'h40, 1);
    req("R4 broadcast noself", 2'd0, 0, 8'hFF, 3'd4, 8'd9, 8'h41, 0);
    req("R5 phys self", 2'd0, 0, 8'd3, 3'd0, 8'd3, 8'h50, 0);
    req("R5 phys other", 2'd0, 0, 8'd6, 3'd0, 8'd3, 8'h51, 0);
    req("R5 phys out", 2'd0, 0, 8'd8, 3'd0, 8'd3, 8'h52, 0);
    req("R6 self", 2'd1, 0, 8'd7, 3'd2, 8'd0, 8'h60, 1);
    req("R7 all", 2'd2, 0, 8'd0, 3'd0, 8'd7, 8'h70, 0);
    req("R8 others", 2'd3, 1, 8'd0, 3'd5, 8'd1, 8'h80, 0);
    req("R9 lowest", 2'd3, 0, 8'd0, 3'b001, 8'd1, 8'h90, 0);
    req("R9 rsv3", 2'd2, 0, 8'd0, 3'b011, 8'd1, 8'h91, 0);
    req("R9 rsv6", 2'd0, 0, 8'hFF, 3'b110, 8'd1, 8'h92, 0);
    @(negedge clk);
    chk("R2 pulse ends", {out_valid, local_raise, req_err, remote_mask}, 0);
    chk("R10 count hold", 32'(pending_cnt), 32'(exp_cnt));

    for (int k = 0; k < 400; k++) begin
      logic [7:0] sid, d;
      sid = 8'($urandom_range(0, 9));
      case ($urandom_range(0, 3))
        0: d = 8'hFF;
        1: d = sid;
        2: d = 8'($urandom_range(0, 11));
        default: d = 8'($urandom);
      endcase
      req("R3 rand", 2'($urandom), 1'($urandom), d, 3'($urandom), sid, 8'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        chk("R2 rand gap", {out_valid, local_raise, req_err}, 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule